// File: doc/BRIEF.md
# Pre-trigger sample capture controller

This block records an 8-channel digital input bus into a circular sample memory. Once a run command arrives, it takes one sample every (decimation + 1) cycles of the 125 MHz base clock. At decimation 0 that is one sample every 8 ns. Lower rates come from larger decimation values, for example 124 for 1 MS/s. Each sample goes out as a write on the memory port. The recorded time window equals the capture depth divided by the resulting sample rate.

A programmable pre-trigger count divides the capture into two parts. Samples taken before the trigger fill a ring. An external trigger-hit strobe is accepted only after at least the pre-trigger count of samples has been written. After an accepted trigger, exactly depth minus pre-trigger further samples are written, and the block then reports done. In the done state it presents the ring address of the oldest sample, so that a reader can unroll the capture in time order. A stop command aborts a capture at any point.

The memory write port has a valid strobe but no ready. Samples arrive at a fixed rate from the pins, and the memory must accept every write in the cycle it is offered. The sample bus is likewise sampled without a handshake. Run, stop, trigger, configuration and status are plain level or pulse signals. Configuration is latched when a run command is accepted, so changing it during a capture has no effect.

Top module: `pcap_capture_ctrl`

## Requirements
- R1: After reset, status reads stopped (code 0), no memory write is issued and the start address reads 0.
- R2: An accepted run sets status to waiting (code 1), and status stays 1 until the capture ends. Each write carries the value on the sample bus in the cycle it is issued. Status codes are 0 stopped, 1 waiting, 2 done, and code 3 never appears.
- R3: While capturing, writes occur in the first cycle after run and then every (decimation + 1) cycles; decimation 0 writes every cycle.
- R4: Write addresses start at 0 after run and increment by one, wrapping to 0 after address depth-1. The effective depth is the configured depth, or the parameter DEPTH if the configured value is 0 or larger than DEPTH.
- R5: A trigger-hit is ignored unless the number of writes since run, not counting the current cycle, is at least the pre-trigger count. The pre-trigger count is clamped to the effective depth.
- R6: After an accepted trigger, exactly (depth - pre-trigger) more writes are issued, and status becomes done (code 2) in the cycle after the last of them. If that difference is 0, status becomes done in the cycle after the trigger.
- R7: In the done state no writes are issued. The start address equals the next write address, which is the address of the oldest stored sample. Outside the done state the start address is 0.
- R8: A stop command returns status to stopped in the next cycle and suppresses any write in its own cycle. Stop has priority over a run in the same cycle.
- R9: A run command in any state, including mid-capture and done, restarts the capture with freshly latched configuration and suppresses the write in its own cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_data_i | input | NCH (8) | Sampled digital channel bus |
| trig_hit_i | input | 1 | Trigger condition met this cycle |
| run_i | input | 1 | Start or restart a capture (pulse) |
| stop_i | input | 1 | Abort capture (pulse) |
| cfg_decim_i | input | DIV_W (16) | Extra base clocks between samples |
| cfg_pre_i | input | CW (11) | Samples to keep before the trigger |
| cfg_depth_i | input | CW (11) | Total capture depth, 0 meaning DEPTH |
| status_o | output | 2 | 0 stopped, 1 waiting, 2 done |
| mem_we_o | output | 1 | Sample memory write strobe |
| mem_addr_o | output | AW (10) | Sample memory write address |
| mem_wdata_o | output | NCH (8) | Sample memory write data |
| start_addr_o | output | AW (10) | Oldest-sample address when done |

## Verification
A wrong divider count shows up in the same cycle as a write strobe that comes early or late. A wrong ring pointer shows on the next write address, and again in the start address once the capture completes. An error in the fill counter or the trigger gate does not appear at once: a trigger taken too early or too late is seen only when the done status arrives earlier or later than expected. The bench's cycle model therefore compares status, strobe, address, data and start address on every clock. It also counts the writes observed after the trigger, so a post-count error is reported at the end of each capture.

// File: rtl/pcap_pkg.sv
package pcap_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_POST = 2'd2,
    ST_DONE = 2'd3
  } cap_state_e;

  localparam logic [1:0] STAT_STOPPED = 2'd0;
  localparam logic [1:0] STAT_WAITING = 2'd1;
  localparam logic [1:0] STAT_DONE    = 2'd2;

endpackage

// File: rtl/pcap_rate_div.sv
module pcap_rate_div #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart_i,
  input  logic             enable_i,
  input  logic [DIV_W-1:0] decim_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q;

  assign tick_o = enable_i && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart_i) begin
      cnt_q <= '0;
    end else if (enable_i) begin
      cnt_q <= (cnt_q == '0) ? decim_i : cnt_q - 1'b1;
    end
  end

  // R3: with a nonzero decimation two samples never land on adjacent cycles
  a_r3_sample_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && decim_i != '0) |=> !tick_o);

endmodule

// File: rtl/pcap_wr_ptr.sv
module pcap_wr_ptr #(
  parameter int DEPTH = 1024,
  parameter int AW    = 10,
  parameter int CW    = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart_i,
  input  logic          we_i,
  input  logic [CW-1:0] depth_i,
  output logic [AW-1:0] wptr_o,
  output logic [CW-1:0] fill_o
);

  logic [AW-1:0] wptr_q;
  logic [CW-1:0] fill_q;
  logic          at_last;

  assign at_last = ((CW'(wptr_q) + CW'(1)) >= depth_i);
  assign wptr_o  = wptr_q;
  assign fill_o  = fill_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      fill_q <= '0;
    end else if (restart_i) begin
      wptr_q <= '0;
      fill_q <= '0;
    end else if (we_i) begin
      wptr_q <= at_last ? '0 : wptr_q + 1'b1;
      if (fill_q != CW'(DEPTH)) fill_q <= fill_q + 1'b1;
    end
  end

  // R4: each write moves the pointer by one or wraps it to zero
  a_r4_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (wptr_q == '0 || wptr_q == $past(wptr_q) + AW'(1)));

  // R4: the pointer stays inside the active ring
  a_r4_ptr_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (CW'(wptr_q) < depth_i));

endmodule

// File: rtl/pcap_ctrl_fsm.sv
module pcap_ctrl_fsm
  import pcap_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int CW    = 11,
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             stop_i,
  input  logic             trig_i,
  input  logic             tick_i,
  input  logic [CW-1:0]    fill_i,
  input  logic [DIV_W-1:0] cfg_decim_i,
  input  logic [CW-1:0]    cfg_pre_i,
  input  logic [CW-1:0]    cfg_depth_i,
  output cap_state_e       state_o,
  output logic [CW-1:0]    depth_o,
  output logic [DIV_W-1:0] decim_o,
  output logic             restart_o,
  output logic             enable_o
);

  cap_state_e       state_q;
  logic [CW-1:0]    dep_q;
  logic [CW-1:0]    pre_q;
  logic [CW-1:0]    left_q;
  logic [DIV_W-1:0] decim_q;
  logic [CW-1:0]    eff_dep;
  logic [CW-1:0]    eff_pre;
  logic             trig_ok;

  assign eff_dep = (cfg_depth_i == '0 || cfg_depth_i > CW'(DEPTH)) ? CW'(DEPTH) : cfg_depth_i;
  assign eff_pre = (cfg_pre_i > eff_dep) ? eff_dep : cfg_pre_i;

  assign restart_o = run_i && !stop_i;
  assign enable_o  = (state_q == ST_PRE || state_q == ST_POST) && !run_i && !stop_i;
  assign trig_ok   = trig_i && (fill_i >= pre_q);

  assign state_o = state_q;
  assign depth_o = dep_q;
  assign decim_o = decim_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      dep_q   <= CW'(DEPTH);
      pre_q   <= '0;
      left_q  <= '0;
      decim_q <= '0;
    end else if (stop_i) begin
      state_q <= ST_IDLE;
    end else if (run_i) begin
      state_q <= ST_PRE;
      dep_q   <= eff_dep;
      pre_q   <= eff_pre;
      decim_q <= cfg_decim_i;
    end else begin
      case (state_q)
        ST_PRE: begin
          if (trig_ok) begin
            left_q  <= dep_q - pre_q;
            state_q <= (dep_q == pre_q) ? ST_DONE : ST_POST;
          end
        end
        ST_POST: begin
          if (tick_i) begin
            left_q <= left_q - 1'b1;
            if (left_q == CW'(1)) state_q <= ST_DONE;
          end
        end
        default: ;
      endcase
    end
  end

  // R8: stop always lands in the stopped state
  a_r8_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> state_q == ST_IDLE);

  // R9: an accepted run always re-arms the pre-trigger phase
  a_r9_run_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !stop_i) |=> state_q == ST_PRE);

  // R5: no trigger is taken while the pre-trigger part is still filling
  a_r5_trigger_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PRE && fill_i < pre_q && !run_i && !stop_i) |=> state_q == ST_PRE);

  // R6: the post phase always has writes outstanding
  a_r6_post_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_POST) |-> left_q != '0);

endmodule

// File: rtl/pcap_capture_ctrl.sv
module pcap_capture_ctrl
  import pcap_pkg::*;
#(
  parameter int NCH   = 8,
  parameter int DEPTH = 1024,
  parameter int DIV_W = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   smp_data_i,
  input  logic             trig_hit_i,
  input  logic             run_i,
  input  logic             stop_i,
  input  logic [DIV_W-1:0] cfg_decim_i,
  input  logic [CW-1:0]    cfg_pre_i,
  input  logic [CW-1:0]    cfg_depth_i,
  output logic [1:0]       status_o,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [NCH-1:0]   mem_wdata_o,
  output logic [AW-1:0]    start_addr_o
);

  cap_state_e       state;
  logic [CW-1:0]    depth;
  logic [DIV_W-1:0] decim;
  logic             restart;
  logic             enable;
  logic             tick;
  logic [AW-1:0]    wptr;
  logic [CW-1:0]    fill;

  pcap_ctrl_fsm #(.DEPTH(DEPTH), .CW(CW), .DIV_W(DIV_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .run_i(run_i), .stop_i(stop_i), .trig_i(trig_hit_i), .tick_i(tick),
    .fill_i(fill), .cfg_decim_i(cfg_decim_i), .cfg_pre_i(cfg_pre_i),
    .cfg_depth_i(cfg_depth_i), .state_o(state), .depth_o(depth),
    .decim_o(decim), .restart_o(restart), .enable_o(enable)
  );

  pcap_rate_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .restart_i(restart), .enable_i(enable),
    .decim_i(decim), .tick_o(tick)
  );

  pcap_wr_ptr #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .restart_i(restart), .we_i(tick),
    .depth_i(depth), .wptr_o(wptr), .fill_o(fill)
  );

  always_comb begin
    case (state)
      ST_PRE, ST_POST: status_o = STAT_WAITING;
      ST_DONE:         status_o = STAT_DONE;
      default:         status_o = STAT_STOPPED;
    endcase
  end

  assign mem_we_o     = tick;
  assign mem_addr_o   = wptr;
  assign mem_wdata_o  = smp_data_i;
  assign start_addr_o = (state == ST_DONE) ? wptr : '0;

  // R7: a finished capture is never overwritten
  a_r7_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o == STAT_DONE) |-> !mem_we_o);

  // R7: the start address holds steady while done persists
  a_r7_start_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o == STAT_DONE && !run_i && !stop_i) |=> $stable(start_addr_o));

  // R2: the unused status code never appears
  a_r2_status_code: assert property (@(posedge clk) disable iff (!rst_n)
    status_o != 2'd3);

endmodule

// File: tb/pcap_capture_ctrl_tb_top.sv
module pcap_capture_ctrl_tb_top;

  localparam int NCH = 8, DEPTH = 1024, DIV_W = 16, AW = 10, CW = 11;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NCH-1:0]   smp_data_i = '0;
  logic             trig_hit_i = 1'b0, run_i = 1'b0, stop_i = 1'b0;
  logic [DIV_W-1:0] cfg_decim_i = '0;
  logic [CW-1:0]    cfg_pre_i = '0, cfg_depth_i = '0;
  logic [1:0]       status_o;
  logic             mem_we_o;
  logic [AW-1:0]    mem_addr_o, start_addr_o;
  logic [NCH-1:0]   mem_wdata_o;

  always #4 clk = ~clk;

  pcap_capture_ctrl #(.NCH(NCH), .DEPTH(DEPTH), .DIV_W(DIV_W)) dut_i (.*);

  int errors = 0, checks = 0, cyc_n = 0;
  bit finished = 0;
  // behavioural reference: 0 idle, 1 pre, 2 post, 3 done
  int m_st = 0, m_div = 0, m_wptr = 0, m_fill = 0, m_left = 0;
  int m_dep = DEPTH, m_pre = 0, m_dec = 0;
  int pre_seen = 0, post_seen = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc_n);
    end
  endtask

  task automatic cyc(input bit r, input bit s, input bit t);
    bit act, tick;
    int exp_stat;
    @(negedge clk);
    cyc_n++;
    run_i = r; stop_i = s; trig_hit_i = t;
    smp_data_i = NCH'(cyc_n * 37 + (cyc_n >> 3));
    #1;
    act  = (m_st == 1 || m_st == 2);
    tick = act && !r && !s && (m_div == 0);
    exp_stat = (m_st == 0) ? 0 : (m_st == 3) ? 2 : 1;
    chk("R3 write strobe", int'(mem_we_o), int'(tick));
    if (tick) begin
      chk("R4 write address", int'(mem_addr_o), m_wptr);
      chk("R2 write data", int'(mem_wdata_o), int'(smp_data_i));
    end
    chk("R2 status", int'(status_o), exp_stat);
    chk("R7 start address", int'(start_addr_o), (m_st == 3) ? m_wptr : 0);
    if (mem_we_o && m_st == 1) pre_seen++;
    if (mem_we_o && m_st == 2) post_seen++;
    // advance the reference to the state after the coming edge
    if (s) m_st = 0;
    else if (r) begin
      m_dep = (cfg_depth_i == 0 || cfg_depth_i > DEPTH) ? DEPTH : int'(cfg_depth_i);
      m_pre = (cfg_pre_i > m_dep) ? m_dep : int'(cfg_pre_i);
      m_dec = int'(cfg_decim_i);
      m_st = 1; m_div = 0; m_wptr = 0; m_fill = 0;
      pre_seen = 0; post_seen = 0;
    end else if (act) begin
      int fill_old;
      fill_old = m_fill;
      m_div = (m_div == 0) ? m_dec : m_div - 1;
      if (tick) begin
        m_wptr = (m_wptr + 1) % m_dep;
        if (m_fill < DEPTH) m_fill++;
      end
      if (m_st == 1) begin
        if (t && fill_old >= m_pre) begin
          m_left = m_dep - m_pre;
          m_st = (m_left == 0) ? 3 : 2;
        end
      end else if (tick) begin
        m_left--;
        if (m_left == 0) m_st = 3;
      end
    end
  endtask

  task automatic capture(input int dep, input int pre, input int dec,
                         input int early, input int trig_at);
    int k;
    cfg_depth_i = CW'(dep); cfg_pre_i = CW'(pre); cfg_decim_i = DIV_W'(dec);
    cyc(1, 0, 0);
    k = 0;
    while (m_st != 3 && k < 20000) begin
      cyc(0, 0, (k == early) || (k >= trig_at && m_st == 1));
      k++;
    end
    cyc(0, 0, 1);
    cyc(0, 0, 0);
    chk("R6 done reached", int'(status_o), 2);
    chk("R6 post-trigger writes", post_seen, m_dep - m_pre);
    chk("R5 pre-trigger writes cover count", int'(pre_seen >= m_pre), 1);
    chk("R7 oldest address", int'(start_addr_o), (pre_seen + post_seen) % m_dep);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #3;
    chk("R1 reset status", int'(status_o), 0);
    chk("R1 reset no write", int'(mem_we_o), 0);
    chk("R1 reset start address", int'(start_addr_o), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc(0, 0, 1);
    chk("R1 idle ignores trigger", int'(status_o), 0);

    capture(16, 4, 0, 1, 6);       // R5 early pulse ignored, R4 wrap
    capture(0, 100, 2, 3, 50);     // R4 depth 0 means DEPTH, R3 decimation
    capture(16, 16, 1, 100, 0);    // R6 zero post count
    capture(16, 0, 0, 100, 0);     // R5 immediate trigger with pre 0
    capture(2000, 1000, 0, 100, 0);// R4 clamp to DEPTH
    capture(20, 50, 3, 100, 5);    // R5 pre clamped to depth

    // R8 stop mid capture and stop over run
    cfg_depth_i = 32; cfg_pre_i = 8; cfg_decim_i = 0;
    cyc(1, 0, 0);
    repeat (5) cyc(0, 0, 0);
    cyc(0, 1, 0);
    cyc(0, 0, 0);
    chk("R8 stop aborts", int'(status_o), 0);
    cyc(1, 1, 0);
    cyc(0, 0, 0);
    chk("R8 stop beats run", int'(status_o), 0);

    // R9 restart mid post phase and from done
    cyc(1, 0, 0);
    repeat (10) cyc(0, 0, 1);
    repeat (5) cyc(0, 0, 0);
    cyc(1, 0, 0);
    cyc(0, 0, 0);
    chk("R9 restart rearms", int'(status_o), 1);
    chk("R9 restart address zero", int'(mem_addr_o), 0);
    capture(8, 3, 0, 100, 0);
    cyc(1, 0, 0);
    cyc(0, 0, 0);
    chk("R9 run from done", int'(status_o), 1);
    repeat (4) cyc(0, 0, 0);

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule